// File: doc/BRIEF.md
# Reloading Interval Timer

This block is a down-counting interval timer. A 12-bit counter steps down by one on every cycle in which the single-cycle `tickEn` input is high. `tickEn` normally comes from a clock divider or clock-source selector elsewhere in the chip. On a tick where the counter already reads zero (terminal count), the counter is reloaded from a 12-bit interval register. When that interval is non-zero, a one-cycle interrupt pulse is raised in the next cycle. The spacing between pulses is therefore interval+1 ticks.

Software reaches the block through a small byte-wide register port. Two addresses return the live count, split into a low byte and a zero-padded high nibble. The other two addresses hold the interval. A write to the interval low byte only fills a staging register. The following write to the interval high nibble commits all 12 bits in one step, so the reload logic never sees a half-updated interval. A committed interval takes effect at the next terminal count.

Top module: `reload_interval_timer`

## Requirements
- R1: After reset the count, the committed interval and the staging byte are zero, `irqPulse` is low, and every address reads back zero.
- R2: A cycle with `tickEn` high and a non-zero count lowers the count by exactly one. A cycle with `tickEn` low leaves the count unchanged.
- R3: A cycle with `tickEn` high and a count of zero loads the count with the committed interval. With a non-zero interval N, terminal counts are therefore N+1 ticks apart.
- R4: `irqPulse` is high for exactly one cycle, in the cycle after each terminal-count tick, when the committed interval is non-zero.
- R5: While the committed interval is zero, `irqPulse` stays low no matter how many ticks arrive, and the count stays at zero.
- R6: A write to address 2 places `regWrData` in the staging byte only. The committed interval (read back at addresses 2 and 3) and the counter behaviour do not change.
- R7: A write to address 3 commits the interval as {`regWrData[3:0]`, staging byte}, and bits 7:4 of the write data are ignored. The current count is not disturbed, and the new interval is first used at the next terminal count.
- R8: Reads are combinational. Address 0 returns count[7:0], address 1 returns {4'b0, count[11:8]}, address 2 returns interval[7:0], and address 3 returns {4'b0, interval[11:8]}.
- R9: Writes to addresses 0 and 1 have no effect on the count or on the interval.
- R10: When an interval commit and a terminal-count tick fall in the same cycle, the reload uses the interval committed before that cycle, and the new value governs the following period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Single-cycle count enable from the timer clock source |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0/1 count, 2/3 interval) |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Combinational register read data |
| irqPulse | output | 1 | One-cycle interrupt request at terminal count |

## Verification
The hardest case to reach is an interval commit that lands in exactly the cycle of a terminal-count tick. The stimulus gets there by running a small interval, reading the live count down to zero through the register port, and then issuing the high-nibble write and the tick on the same edge. The length of the following two periods then shows which interval was used. Beyond that corner, the bench sweeps many intervals, from 1 up to the 12-bit maximum, under both a dense and a sparse tick pattern. It checks the spacing between pulses against interval+1, as well as the count at reload and after a few forced ticks.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  // Register addresses; the count/interval split by byte is fixed by software.
  localparam logic [1:0] ADDR_CNT_LO = 2'd0;
  localparam logic [1:0] ADDR_CNT_HI = 2'd1;
  localparam logic [1:0] ADDR_IVL_LO = 2'd2;
  localparam logic [1:0] ADDR_IVL_HI = 2'd3;

  // Strobes from the control to the datapath, all valid for one cycle.
  typedef struct packed {
    logic stageLow;    // latch low interval byte into staging
    logic commitHigh;  // commit {nibble, staging} as the interval
    logic reload;      // terminal-count tick: count <= interval
    logic decrement;   // ordinary tick: count <= count - 1
    logic raiseIrq;    // request a pulse in the next cycle
  } ivt_strobe_t;
endpackage

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
  import ivt_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic              tickEn,
  input  logic              countZero,
  input  logic              intervalNonZero,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  interval,
  output ivt_strobe_t       strb,
  output logic [DATA_W-1:0] regRdData
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [DATA_W-1:0] countHiPad;
  logic [DATA_W-1:0] intervalHiPad;

  always_comb begin
    strb.stageLow   = regWrEn && (regAddr == ADDR_IVL_LO);
    strb.commitHigh = regWrEn && (regAddr == ADDR_IVL_HI);
    strb.reload     = tickEn && countZero;
    strb.decrement  = tickEn && !countZero;
    strb.raiseIrq   = tickEn && countZero && intervalNonZero;
  end

  generate
    if (HI_W < DATA_W) begin : g_pad
      assign countHiPad    = {{(DATA_W-HI_W){1'b0}}, count[CNT_W-1:DATA_W]};
      assign intervalHiPad = {{(DATA_W-HI_W){1'b0}}, interval[CNT_W-1:DATA_W]};
    end else begin : g_full
      assign countHiPad    = count[CNT_W-1:DATA_W];
      assign intervalHiPad = interval[CNT_W-1:DATA_W];
    end
  endgenerate

  always_comb begin
    unique case (regAddr)
      ADDR_CNT_LO: regRdData = count[DATA_W-1:0];
      ADDR_CNT_HI: regRdData = countHiPad;
      ADDR_IVL_LO: regRdData = interval[DATA_W-1:0];
      default:     regRdData = intervalHiPad;
    endcase
  end
endmodule

// File: rtl/ivt_datapath.sv
module ivt_datapath
  import ivt_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ivt_strobe_t       strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  interval,
  output logic              countZero,
  output logic              intervalNonZero,
  output logic              irq
);
  localparam int HI_W = CNT_W - DATA_W;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] stageLo;

  assign countZero       = (count == '0);
  assign intervalNonZero = |interval;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageLo  <= '0;
      interval <= '0;
      count    <= '0;
      irq      <= 1'b0;
    end else begin
      if (strb.stageLow)   stageLo  <= wrData;
      if (strb.commitHigh) interval <= {wrData[HI_W-1:0], stageLo};
      if (strb.reload)         count <= interval;
      else if (strb.decrement) count <= count - ONE;
      irq <= strb.raiseIrq;
    end
  end

  // R2: an ordinary tick lowers the count by one
  p_decrement_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.decrement |=> count == $past(count) - ONE);
  // R2: without a tick the count holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.reload || strb.decrement) |=> $stable(count));
  // R3, R10: reload takes the interval committed before the tick
  p_reload_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> count == $past(interval));
  // R4: the request never lasts more than one cycle
  p_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  // R5: no request is raised from a zero interval
  p_zero_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(interval) != '0);
  // R6: the interval changes only on a commit
  p_stage_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commitHigh |=> $stable(interval));
  // R7: commit joins the written nibble with the staged byte
  p_commit_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitHigh |=> interval == {$past(wrData[HI_W-1:0]), $past(stageLo)});
endmodule

// File: rtl/reload_interval_timer.sv
module reload_interval_timer
  import ivt_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqPulse
);
  ivt_strobe_t      strb;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] interval;
  logic             countZero;
  logic             intervalNonZero;

  ivt_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .tickEn(tickEn),
    .countZero(countZero), .intervalNonZero(intervalNonZero),
    .count(count), .interval(interval), .strb(strb), .regRdData(regRdData)
  );

  ivt_datapath #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData),
    .count(count), .interval(interval), .countZero(countZero),
    .intervalNonZero(intervalNonZero), .irq(irqPulse)
  );
endmodule

// File: tb/reload_interval_timer_tb.sv
module reload_interval_timer_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN;
  logic       tickEn = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       irqPulse;

  int checks = 0;
  int errors = 0;
  int mode = 0;
  int phase = 0;
  bit irqSeen = 1'b0;
  bit done = 1'b0;

  reload_interval_timer u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqPulse(irqPulse)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle from a falling edge; sample irq at the next falling edge.
  task automatic step(input bit en);
    tickEn = en;
    @(negedge clk);
    irqSeen = irqPulse;
    tickEn = 1'b0;
  endtask

  task automatic stepPat(inout int ticks);
    bit en;
    phase++;
    en = (mode == 0) || (phase % 3 == 0);
    if (en) ticks++;
    step(en);
  endtask

  task automatic writeReg(input logic [1:0] addr, input logic [7:0] data);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    step(1'b0);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] addr, output int val);
    regAddr = addr;
    #1;
    val = int'(regRdData);
  endtask

  task automatic readCount(output int val);
    int lo, hi;
    readReg(2'd0, lo);
    readReg(2'd1, hi);
    val = lo + hi * 256;
  endtask

  task automatic waitIrq(input string req, output int ticks);
    bit ok = 1'b0;
    ticks = 0;
    for (int i = 0; i < 20000; i++) begin
      stepPat(ticks);
      if (irqSeen) begin ok = 1'b1; break; end
    end
    check({req, " irq arrives"}, int'(ok), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, t, k, n;
    int vals [14] = '{1, 2, 3, 4, 5, 7, 8, 15, 16, 31, 255, 256, 1000, 4095};
    bit anyIrq;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      readReg(a[1:0], v);
      check("R1 reset readback", v, 0);
    end
    check("R1 irq low", int'(irqPulse), 0);

    // R5: zero interval never raises a request
    anyIrq = 1'b0;
    for (int i = 0; i < 20; i++) begin step(1'b1); anyIrq |= irqSeen; end
    check("R5 no irq at zero interval", int'(anyIrq), 0);
    readCount(v);
    check("R5 count stays zero", v, 0);

    // R6: staging write leaves the committed interval alone
    writeReg(2'd2, 8'h05);
    readReg(2'd2, v); check("R6 interval low unchanged", v, 0);
    readReg(2'd3, v); check("R6 interval high unchanged", v, 0);
    anyIrq = 1'b0;
    for (int i = 0; i < 10; i++) begin step(1'b1); anyIrq |= irqSeen; end
    check("R6 still no irq", int'(anyIrq), 0);

    // R9: writes to the count addresses are ignored
    writeReg(2'd0, 8'hFF);
    writeReg(2'd1, 8'hFF);
    readCount(v); check("R9 count unaffected", v, 0);
    readReg(2'd2, v); check("R9 interval low unaffected", v, 0);

    // R7, R8: commit with upper data bits set
    writeReg(2'd3, 8'hF3);
    readReg(2'd2, v); check("R7 committed low byte", v, 5);
    readReg(2'd3, v); check("R8 high nibble zero padded", v, 3);

    // R2, R3, R4: sweep intervals under dense and sparse ticks
    for (int m = 0; m < 2; m++) begin
      mode = m;
      foreach (vals[i]) begin
        n = vals[i];
        writeReg(2'd2, 8'(n));
        writeReg(2'd3, 8'(n >> 8));
        waitIrq("R4 sync", t);
        readCount(v); check("R3 count reloaded", v, n);
        k = (n < 3) ? n : 3;
        for (int j = 0; j < k; j++) begin
          step(1'b1);
          if (j == 0) check("R4 single-cycle pulse", int'(irqSeen), 0);
        end
        readCount(v); check("R2 decrement by one per tick", v, n - k);
        for (int j = 0; j < 4; j++) step(1'b0);
        readCount(v); check("R2 hold without tick", v, n - k);
        waitIrq("R3", t);
        check("R3 period is interval+1 ticks", t + k, n + 1);
      end
    end

    // R7: a new interval does not disturb the running count
    mode = 0;
    writeReg(2'd2, 8'd10); writeReg(2'd3, 8'd0);
    waitIrq("R7 sync", t);
    for (int j = 0; j < 3; j++) step(1'b1);
    writeReg(2'd2, 8'd2); writeReg(2'd3, 8'd0);
    readCount(v); check("R7 count undisturbed", v, 7);
    waitIrq("R7", t); check("R7 old period finishes", t, 8);
    waitIrq("R7", t); check("R7 new period used", t, 3);

    // R10: commit in the same cycle as the terminal tick
    writeReg(2'd2, 8'd6);
    step(1'b1); step(1'b1);
    readCount(v); check("R10 count at zero", v, 0);
    regWrEn = 1'b1; regAddr = 2'd3; regWrData = 8'd0;
    step(1'b1);
    regWrEn = 1'b0;
    check("R10 irq on coinciding tick", int'(irqSeen), 1);
    readCount(v); check("R10 reload uses old interval", v, 2);
    waitIrq("R10", t); check("R10 remaining old period", t, 3);
    waitIrq("R10", t); check("R10 new interval period", t, 7);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule